// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the step controller of a small 16-bit RISC core whose instruction memory is one byte wide. Each instruction is collected with two byte reads on two back-to-back cycles: the low byte first, the high byte second. After that, the controller may hold the core in extra execute cycles, depending on the kind of instruction. It raises a one-cycle retire pulse in the final cycle of each instruction, and the next fetch starts on the following cycle.

A single active token moves through three one-hot phases: low fetch, high fetch and execute. A down-counter sets how long the execute phase lasts. The instruction class and the second multiply operand are taken from the surrounding decode logic in the high-fetch cycle only. That decode logic can form them from the low byte already held in the instruction register and the high byte on the read port.

The number of extra cycles depends on the class:

- Loads and stores take one extra cycle for a byte access and two for a word access.
- Multiply takes as many extra cycles as the position of the highest set bit of its second operand.
- Divide always takes a fixed sixteen.
- Every other class takes none.

Top module: `insn_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `fetch_addr` is 0, `instr` is 0, `fetch_lo_en` is 1 and `retire` is 0.
- R2: Every instruction begins with one cycle of `fetch_lo_en` and then one cycle of `fetch_hi_en`. `fetch_addr` rises by one after each of these two cycles. The byte read in the first cycle becomes `instr[7:0]`, and the byte read in the second becomes `instr[15:8]`.
- R3: Classes 3'b000 and 3'b111 add no execute cycles, so `retire` is high in the high-fetch cycle and the instruction takes 2 cycles.
- R4: Class 3'b001 (byte load) and class 3'b011 (byte store) add 1 execute cycle. Class 3'b010 (word load) and class 3'b100 (word store) add 2.
- R5: Class 3'b101 (multiply) adds N execute cycles. N is the 1-based position of the highest set bit of `mul_operand`, so bit 0 gives 1 and bit 15 gives 16. An operand of zero gives 0 extra cycles, with retire in the high-fetch cycle.
- R6: Class 3'b110 (divide) adds exactly 16 execute cycles for any operand value.
- R7: Exactly one of `fetch_lo_en`, `fetch_hi_en` and `exec_en` is high in every cycle. `fetch_addr` stays still during execute cycles.
- R8: `retire` is high for exactly one cycle per instruction, in its last cycle. The next cycle is a low-fetch cycle.
- R9: `insn_class` and `mul_operand` are sampled only at the end of the high-fetch cycle. Changing them during execute cycles has no effect on the instruction's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Byte read from instruction memory at `fetch_addr`, same cycle |
| insn_class | input | 3 | Decoded instruction class, used in the high-fetch cycle |
| mul_operand | input | 16 | Second multiply operand, used in the high-fetch cycle |
| fetch_addr | output | ADDR_W | Program counter / byte fetch address |
| instr | output | 16 | Assembled instruction register |
| fetch_lo_en | output | 1 | Low-byte fetch step active |
| fetch_hi_en | output | 1 | High-byte fetch step active |
| exec_en | output | 1 | Extra execute step active |
| retire | output | 1 | Last cycle of the current instruction |

## Verification
The retire pulse and the high-byte capture fall in the same cycle whenever an instruction adds no execute cycles. This happens for plain classes and for a multiply with a zero operand. Such instructions are run back to back with longer ones, in directed cases and in a seeded random stream. Each instruction's measured cycle count is judged against a bench model. After every retire, the bench checks the assembled instruction word and the advanced fetch address. The class and operand are scrambled during execute cycles to show that they are ignored there.

// File: rtl/insn_sequencer.sv
module insn_sequencer #(
  parameter int ADDR_W    = 16,
  parameter int DIV_STEPS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        mem_rdata,
  input  logic [2:0]        insn_class,
  input  logic [15:0]       mul_operand,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [15:0]       instr,
  output logic              fetch_lo_en,
  output logic              fetch_hi_en,
  output logic              exec_en,
  output logic              retire
);
  localparam int MAX_STEPS = (DIV_STEPS > 16) ? DIV_STEPS : 16;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);
  localparam int T_LO = 0, T_HI = 1, T_EX = 2;

  logic [2:0]        tok;
  logic [CNT_W-1:0]  cnt, extra, msb_pos;
  logic [ADDR_W-1:0] pc;

  always_comb begin
    msb_pos = '0;
    for (int i = 0; i < 16; i++)
      if (mul_operand[i]) msb_pos = CNT_W'(i + 1);
  end

  always_comb begin
    case (insn_class)
      3'b001, 3'b011: extra = CNT_W'(1);
      3'b010, 3'b100: extra = CNT_W'(2);
      3'b101:         extra = msb_pos;
      3'b110:         extra = CNT_W'(DIV_STEPS);
      default:        extra = '0;
    endcase
  end

  assign fetch_lo_en = tok[T_LO];
  assign fetch_hi_en = tok[T_HI];
  assign exec_en     = tok[T_EX];
  assign fetch_addr  = pc;
  assign retire      = (tok[T_HI] && extra == '0) || (tok[T_EX] && cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tok   <= 3'b001;
      pc    <= '0;
      instr <= '0;
      cnt   <= '0;
    end else begin
      unique case (1'b1)
        tok[T_LO]: begin
          instr[7:0] <= mem_rdata;
          pc         <= pc + 1'b1;
          tok        <= 3'b010;
        end
        tok[T_HI]: begin
          instr[15:8] <= mem_rdata;
          pc          <= pc + 1'b1;
          cnt         <= extra;
          tok         <= (extra == '0) ? 3'b001 : 3'b100;
        end
        default: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) tok <= 3'b001;
        end
      endcase
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones({fetch_lo_en, fetch_hi_en, exec_en}) == 1);  // R7
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (fetch_addr == $past(fetch_addr)));  // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    fetch_lo_en |=> (fetch_hi_en && fetch_addr == $past(fetch_addr) + 1'b1));  // R2
  AST_RETIRE_NEXT: assert property (@(posedge clk) disable iff (rst)
    retire |=> (fetch_lo_en && !retire));  // R8
  AST_PLAIN_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (fetch_hi_en && (insn_class == 3'b000 || insn_class == 3'b111)) |-> retire);  // R3
  AST_MUL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fetch_hi_en && insn_class == 3'b101 && mul_operand == 16'd0) |-> retire);  // R5
  AST_DIV_ENTER: assert property (@(posedge clk) disable iff (rst)
    (fetch_hi_en && insn_class == 3'b110) |=> (exec_en && !retire));  // R6
  AST_BYTE_MEM: assert property (@(posedge clk) disable iff (rst)
    (fetch_hi_en && (insn_class == 3'b001 || insn_class == 3'b011)) |=> (exec_en && retire));  // R4
endmodule

// File: tb/insn_sequencer_tb.sv
module insn_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_rdata;
  logic [2:0]  insn_class = 3'b000;
  logic [15:0] mul_operand = 16'd0;
  logic [15:0] fetch_addr;
  logic [15:0] instr;
  logic        fetch_lo_en, fetch_hi_en, exec_en, retire;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd7) ^ 8'h5A;
  endfunction

  assign mem_rdata = byte_at(fetch_addr);

  function automatic int model_extra(input logic [2:0] c, input logic [15:0] op);
    int p;
    p = 0;
    case (c)
      3'b001, 3'b011: return 1;
      3'b010, 3'b100: return 2;
      3'b101: begin
        for (int i = 0; i < 16; i++) if (op[i]) p = i + 1;
        return p;
      end
      3'b110: return 16;
      default: return 0;
    endcase
  endfunction

  insn_sequencer u_dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .insn_class(insn_class),
    .mul_operand(mul_operand), .fetch_addr(fetch_addr), .instr(instr),
    .fetch_lo_en(fetch_lo_en), .fetch_hi_en(fetch_hi_en), .exec_en(exec_en),
    .retire(retire)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_instr(input logic [2:0] c, input logic [15:0] op, input bit scramble);
    logic [15:0] start;
    int cyc, exp_len, pulses;
    bit seen;
    start = fetch_addr;
    exp_len = 2 + model_extra(c, op);
    check(fetch_lo_en === 1'b1, "R2 low fetch first", fetch_lo_en, 1);
    insn_class = c;
    mul_operand = op;
    cyc = 0; pulses = 0; seen = 1'b0;
    while (!seen && cyc < 40) begin
      cyc++;
      if (retire) begin seen = 1'b1; pulses++; end
      else begin
        if (cyc == 1) check(fetch_hi_en === 1'b0, "R2 step order", fetch_hi_en, 0);
        if (cyc >= 3 && scramble) begin
          insn_class = 3'($urandom);
          mul_operand = 16'($urandom);
        end
        @(negedge clk);
      end
    end
    case (c)
      3'b000, 3'b111: check(cyc == exp_len, "R3 plain length", cyc, exp_len);
      3'b001, 3'b010, 3'b011, 3'b100: check(cyc == exp_len, "R4 load/store length", cyc, exp_len);
      3'b101: check(cyc == exp_len, "R5 multiply length", cyc, exp_len);
      default: check(cyc == exp_len, "R6 divide length", cyc, exp_len);
    endcase
    if (scramble) check(cyc == exp_len, "R9 inputs ignored in execute", cyc, exp_len);
    @(negedge clk);
    check(retire === 1'b0 && fetch_lo_en === 1'b1, "R8 single pulse then fetch", retire, 0);
    check(instr === {byte_at(start + 16'd1), byte_at(start)}, "R2 instr assembly",
          instr, {byte_at(start + 16'd1), byte_at(start)});
    check(fetch_addr === start + 16'd2, "R2 pc advance", fetch_addr, start + 16'd2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check(fetch_addr === 16'd0 && instr === 16'd0, "R1 reset state", fetch_addr, 0);
    check(fetch_lo_en === 1'b1 && retire === 1'b0, "R1 reset step", {fetch_lo_en, retire}, 2);
    rst = 1'b0;
    @(negedge clk);
    check(fetch_addr === 16'd1 && fetch_hi_en === 1'b1, "R1 first fetch after reset", fetch_addr, 1);
    rst = 1'b1;
    @(negedge clk);
    check(fetch_addr === 16'd0 && fetch_lo_en === 1'b1, "R1 reset again", fetch_addr, 0);
    rst = 1'b0;
    // directed corners
    run_instr(3'b000, 16'd0, 1'b0);          // R3
    run_instr(3'b111, 16'hFFFF, 1'b0);       // R3
    run_instr(3'b101, 16'd0, 1'b0);          // R5 zero operand
    run_instr(3'b101, 16'd0, 1'b0);          // R5 back to back
    run_instr(3'b101, 16'd1, 1'b0);          // R5 bit0 -> 1
    run_instr(3'b101, 16'h8000, 1'b1);       // R5 bit15 -> 16, R9
    run_instr(3'b110, 16'd0, 1'b1);          // R6, R9
    run_instr(3'b110, 16'hFFFF, 1'b0);       // R6
    run_instr(3'b001, 16'd0, 1'b0);          // R4
    run_instr(3'b010, 16'd0, 1'b1);          // R4
    run_instr(3'b011, 16'd0, 1'b0);          // R4
    run_instr(3'b100, 16'd0, 1'b0);          // R4
    for (int k = 0; k < 400; k++)
      run_instr(3'($urandom), 16'($urandom) >> ($urandom % 16), ($urandom % 2) == 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule